// File: doc/BRIEF.md
# Integer Decode and Execute Stage

This block is the decode-and-execute step for the 32-bit integer subset of a classic three-register load/store instruction set. It takes one instruction word and the two source register values that a register file has already read for it, the first source and the second source. Within the same cycle, with no clock or storage, it returns the value to write back, the index of the destination register, a write enable, a signed-overflow trap and a reserved-instruction flag.

Register-format instructions (primary opcode zero) select their operation with the low six bits and write the register named in bits 15:11. Immediate-format instructions carry a 16-bit constant in bits 15:0 and write the register named in bits 20:16. Arithmetic constants are always sign-extended, including for the unsigned add and unsigned compare. Logical constants are zero-extended. A trap, a reserved encoding or a destination of register zero each hold back the write. Loads, stores, branches, jumps, multiply/divide and coprocessor encodings are not decoded, so they report as reserved.

Top module: `int_exec_unit`

## Requirements
- R1: Register-format functions 0x20 (add), 0x21 (add, unsigned), 0x22 (subtract) and 0x23 (subtract, unsigned) return the first source plus or minus the second source, modulo 2^32.
- R2: A signed add (function 0x20, or opcode 0x08) or a signed subtract (function 0x22) whose true result does not fit in 32 signed bits raises `ovfTrap` and drops `wrEn`.
- R3: Functions 0x21 and 0x23 and opcode 0x09 never raise `ovfTrap`. Their result wraps silently and is still written.
- R4: Functions 0x24, 0x25, 0x26 and 0x27 return the bitwise AND, OR, XOR and NOR of the two sources.
- R5: Function 0x2A and opcode 0x0A compare as signed. Function 0x2B and opcode 0x0B compare as unsigned. The result is 1 in bit 0 when the first source is below the other operand, and 0 otherwise, with bits 31:1 always zero.
- R6: Functions 0x00, 0x02 and 0x03 shift the second source left logical, right logical and right arithmetic by the 5-bit count in bits 10:6.
- R7: Functions 0x04, 0x06 and 0x07 perform the same three shifts, using only bits 4:0 of the first source as the count.
- R8: Opcodes 0x08, 0x09, 0x0A and 0x0B sign-extend bits 15:0. Opcodes 0x0C, 0x0D and 0x0E AND, OR and XOR the first source with bits 15:0 zero-extended.
- R9: Opcode 0x0F returns bits 15:0 of the instruction in result bits 31:16, with zeros below.
- R10: `dstIdx` is bits 15:11 for opcode 0 and bits 20:16 otherwise. `wrEn` is low whenever `dstIdx` is 0.
- R11: Any opcode other than 0 and 0x08 to 0x0F, and any opcode-0 function outside those listed in R1 and R4 to R7, raises `rsvdInstr`, keeps `ovfTrap` low and drops `wrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| srcA | input | 32 | Value of the register in bits 25:21 |
| srcB | input | 32 | Value of the register in bits 20:16 |
| result | output | 32 | Write-back value |
| dstIdx | output | 5 | Destination register index |
| wrEn | output | 1 | Register write enable |
| ovfTrap | output | 1 | Signed-overflow trap |
| rsvdInstr | output | 1 | Encoding not recognised |

## Verification
The hardest cases to reach are the overflow boundaries. The signed and unsigned forms of add and subtract must be told apart on operands that sit exactly at the 32-bit signed limits, and a sign-extended negative immediate must push past the limit while its unsigned twin wraps and still writes. The stimulus places 0x7FFFFFFF and 0x80000000 against +1 and -1, through both the register forms and the immediate forms. It then repeats a subset with register zero as the destination, so that the trap and the zero-destination suppression are seen separately. Variable shifts get first-source values with high bits set, which shows that only the low five bits count.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;
  localparam int DATA_W  = 32;
  localparam int REG_W   = 5;
  localparam int FIELD_W = 6;
  localparam int IMM_W   = 16;

  typedef enum logic [3:0] {
    OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR, OP_NOR,
    OP_SLT, OP_SLTU, OP_SLL, OP_SRL, OP_SRA, OP_LUI
  } aluOpE;

  typedef struct packed {
    aluOpE aluOp;
    logic  useImm;
    logic  zeroExt;
    logic  varShift;
    logic  destRt;
    logic  trapOvf;
    logic  illegal;
  } ctrlStrobes;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import int_exec_pkg::*;
(
  input  logic [FIELD_W-1:0] opcode,
  input  logic [FIELD_W-1:0] funct,
  output ctrlStrobes         ctrl
);
  always_comb begin
    ctrl = '{aluOp: OP_ADD, useImm: 1'b0, zeroExt: 1'b0, varShift: 1'b0,
             destRt: 1'b0, trapOvf: 1'b0, illegal: 1'b0};
    if (opcode == '0) begin
      unique case (funct)
        6'h20: begin ctrl.aluOp = OP_ADD; ctrl.trapOvf = 1'b1; end
        6'h21: ctrl.aluOp = OP_ADD;
        6'h22: begin ctrl.aluOp = OP_SUB; ctrl.trapOvf = 1'b1; end
        6'h23: ctrl.aluOp = OP_SUB;
        6'h24: ctrl.aluOp = OP_AND;
        6'h25: ctrl.aluOp = OP_OR;
        6'h26: ctrl.aluOp = OP_XOR;
        6'h27: ctrl.aluOp = OP_NOR;
        6'h2A: ctrl.aluOp = OP_SLT;
        6'h2B: ctrl.aluOp = OP_SLTU;
        6'h00: ctrl.aluOp = OP_SLL;
        6'h02: ctrl.aluOp = OP_SRL;
        6'h03: ctrl.aluOp = OP_SRA;
        6'h04: begin ctrl.aluOp = OP_SLL; ctrl.varShift = 1'b1; end
        6'h06: begin ctrl.aluOp = OP_SRL; ctrl.varShift = 1'b1; end
        6'h07: begin ctrl.aluOp = OP_SRA; ctrl.varShift = 1'b1; end
        default: ctrl.illegal = 1'b1;
      endcase
    end else begin
      ctrl.destRt = 1'b1;
      ctrl.useImm = 1'b1;
      unique case (opcode)
        6'h08: begin ctrl.aluOp = OP_ADD; ctrl.trapOvf = 1'b1; end
        6'h09: ctrl.aluOp = OP_ADD;
        6'h0A: ctrl.aluOp = OP_SLT;
        6'h0B: ctrl.aluOp = OP_SLTU;
        6'h0C: begin ctrl.aluOp = OP_AND; ctrl.zeroExt = 1'b1; end
        6'h0D: begin ctrl.aluOp = OP_OR;  ctrl.zeroExt = 1'b1; end
        6'h0E: begin ctrl.aluOp = OP_XOR; ctrl.zeroExt = 1'b1; end
        6'h0F: ctrl.aluOp = OP_LUI;
        default: ctrl.illegal = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/exec_path.sv
module exec_path
  import int_exec_pkg::*;
(
  input  ctrlStrobes        ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [REG_W-1:0]  shamtField,
  output logic [DATA_W-1:0] aluOut,
  output logic              rawOvf
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] immExt, opnd, sumVal, diffVal;
  logic [SH_W-1:0]   shamt;

  always_comb begin
    immExt  = ctrl.zeroExt ? {{(DATA_W-IMM_W){1'b0}}, imm}
                           : {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    opnd    = ctrl.useImm ? immExt : srcB;
    sumVal  = srcA + opnd;
    diffVal = srcA - opnd;
    shamt   = ctrl.varShift ? srcA[SH_W-1:0] : shamtField[SH_W-1:0];
    rawOvf  = 1'b0;
    aluOut  = '0;
    unique case (ctrl.aluOp)
      OP_ADD: begin
        aluOut = sumVal;
        rawOvf = (srcA[DATA_W-1] == opnd[DATA_W-1]) &&
                 (sumVal[DATA_W-1] != srcA[DATA_W-1]);
      end
      OP_SUB: begin
        aluOut = diffVal;
        rawOvf = (srcA[DATA_W-1] != opnd[DATA_W-1]) &&
                 (diffVal[DATA_W-1] != srcA[DATA_W-1]);
      end
      OP_AND:  aluOut = srcA & opnd;
      OP_OR:   aluOut = srcA | opnd;
      OP_XOR:  aluOut = srcA ^ opnd;
      OP_NOR:  aluOut = ~(srcA | opnd);
      OP_SLT:  aluOut = {{(DATA_W-1){1'b0}}, $signed(srcA) < $signed(opnd)};
      OP_SLTU: aluOut = {{(DATA_W-1){1'b0}}, srcA < opnd};
      OP_SLL:  aluOut = srcB << shamt;
      OP_SRL:  aluOut = srcB >> shamt;
      OP_SRA:  aluOut = $unsigned($signed(srcB) >>> shamt);
      OP_LUI:  aluOut = {imm, {(DATA_W-IMM_W){1'b0}}};
      default: aluOut = '0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_exec_pkg::*;
(
  input  logic [31:0] instr,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  output logic [31:0] result,
  output logic [4:0]  dstIdx,
  output logic        wrEn,
  output logic        ovfTrap,
  output logic        rsvdInstr
);
  ctrlStrobes ctrl;
  logic       rawOvf;

  exec_ctrl uCtrl (
    .opcode(instr[31:26]),
    .funct (instr[5:0]),
    .ctrl  (ctrl)
  );

  exec_path uPath (
    .ctrl      (ctrl),
    .srcA      (srcA),
    .srcB      (srcB),
    .imm       (instr[15:0]),
    .shamtField(instr[10:6]),
    .aluOut    (result),
    .rawOvf    (rawOvf)
  );

  always_comb begin
    dstIdx    = ctrl.destRt ? instr[20:16] : instr[15:11];
    ovfTrap   = !ctrl.illegal && ctrl.trapOvf && rawOvf;
    rsvdInstr = ctrl.illegal;
    wrEn      = !ctrl.illegal && !ovfTrap && (dstIdx != '0);
  end
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk (
  input logic [31:0] instr,
  input logic [31:0] result,
  input logic [4:0]  dstIdx,
  input logic        wrEn,
  input logic        ovfTrap,
  input logic        rsvdInstr
);
  logic known;
  logic isUnsArith;
  logic isCompare;

  always_comb begin
    known      = !$isunknown({instr, result, dstIdx, wrEn, ovfTrap, rsvdInstr});
    isUnsArith = (instr[31:26] == 6'h09) ||
                 (instr[31:26] == 6'h00 && (instr[5:0] == 6'h21 || instr[5:0] == 6'h23));
    isCompare  = (instr[31:26] == 6'h0A) || (instr[31:26] == 6'h0B) ||
                 (instr[31:26] == 6'h00 && (instr[5:0] == 6'h2A || instr[5:0] == 6'h2B));
    if (known) begin
      a_r2_trap_blocks_write: assert (!(ovfTrap && wrEn))
        else $error("trap with write enable");
      a_r3_unsigned_no_trap: assert (!(isUnsArith && ovfTrap))
        else $error("unsigned form trapped");
      a_r5_compare_single_bit: assert (!isCompare || result[31:1] == '0)
        else $error("compare result wider than one bit");
      a_r9_lui_low_zero: assert (instr[31:26] != 6'h0F || result[15:0] == '0)
        else $error("upper-immediate low half not zero");
      a_r10_zero_dest_no_write: assert (!(dstIdx == '0 && wrEn))
        else $error("write to register zero");
      a_r11_reserved_quiet: assert (!rsvdInstr || (!wrEn && !ovfTrap))
        else $error("reserved encoding wrote or trapped");
    end
  end
endmodule

bind int_exec_unit int_exec_unit_chk uChk (
  .instr    (instr),
  .result   (result),
  .dstIdx   (dstIdx),
  .wrEn     (wrEn),
  .ovfTrap  (ovfTrap),
  .rsvdInstr(rsvdInstr)
);

// File: tb/int_exec_unit_test.sv
module int_exec_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] instr = '0, srcA = '0, srcB = '0;
  logic [31:0] result;
  logic [4:0]  dstIdx;
  logic        wrEn, ovfTrap, rsvdInstr;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int_exec_unit uut (.*);

  typedef struct {
    string       tag;
    logic        chkRes;
    logic [31:0] res;
    logic [4:0]  dst;
    logic        we, ovf, rsv;
  } expT;

  expT sbQ[$];

  function automatic logic [31:0] rfmt(input int rs, rt, rd, sa, fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sa), 6'(fn)};
  endfunction
  function automatic logic [31:0] ifmt(input int op, rs, rt, input logic [15:0] im);
    return {6'(op), 5'(rs), 5'(rt), im};
  endfunction

  task automatic drive(input string tag, input logic [31:0] i, a, b,
                       input logic chkRes, input logic [31:0] res,
                       input int dst, input logic we, ovf, rsv);
    expT e;
    @(posedge clk);
    #1;
    instr = i; srcA = a; srcB = b;
    e.tag = tag; e.chkRes = chkRes; e.res = res; e.dst = 5'(dst);
    e.we = we; e.ovf = ovf; e.rsv = rsv;
    sbQ.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      expT e;
      e = sbQ.pop_front();
      checks++;
      if ((e.chkRes && result !== e.res) || dstIdx !== e.dst || wrEn !== e.we ||
          ovfTrap !== e.ovf || rsvdInstr !== e.rsv) begin
        errors++;
        $display("FAIL %s: got res=%h dst=%0d we=%b ovf=%b rsv=%b exp res=%h dst=%0d we=%b ovf=%b rsv=%b",
                 e.tag, result, dstIdx, wrEn, ovfTrap, rsvdInstr,
                 e.res, e.dst, e.we, e.ovf, e.rsv);
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got running exp finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Idle state: all-zero word is a shift into register zero
    drive("R10 idle", 32'h0, 32'h0, 32'h0, 1, 32'h0, 0, 0, 0, 0);
    // R1 arithmetic
    drive("R1 add",  rfmt(1,2,3,0,'h20), 32'd100, 32'd23, 1, 32'd123, 3, 1, 0, 0);
    drive("R1 sub",  rfmt(1,2,4,0,'h22), 32'd5, 32'd9, 1, 32'hFFFFFFFC, 4, 1, 0, 0);
    drive("R1 addu", rfmt(1,2,5,0,'h21), 32'hFFFFFFFF, 32'd2, 1, 32'd1, 5, 1, 0, 0);
    drive("R1 subu", rfmt(1,2,6,0,'h23), 32'd0, 32'd1, 1, 32'hFFFFFFFF, 6, 1, 0, 0);
    // R2 signed overflow
    drive("R2 add max+1", rfmt(1,2,7,0,'h20), 32'h7FFFFFFF, 32'd1, 0, 32'h0, 7, 0, 1, 0);
    drive("R2 add min-1", rfmt(1,2,7,0,'h20), 32'h80000000, 32'hFFFFFFFF, 0, 32'h0, 7, 0, 1, 0);
    drive("R2 sub min-1", rfmt(1,2,7,0,'h22), 32'h80000000, 32'd1, 0, 32'h0, 7, 0, 1, 0);
    drive("R2 sub max-(-1)", rfmt(1,2,7,0,'h22), 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 32'h0, 7, 0, 1, 0);
    drive("R2 addi max+1", ifmt('h08,1,8,16'h0001), 32'h7FFFFFFF, 32'h0, 0, 32'h0, 8, 0, 1, 0);
    drive("R2 addi min+(-1)", ifmt('h08,1,8,16'hFFFF), 32'h80000000, 32'h0, 0, 32'h0, 8, 0, 1, 0);
    drive("R2 trap dst0", rfmt(1,2,0,0,'h20), 32'h7FFFFFFF, 32'd1, 0, 32'h0, 0, 0, 1, 0);
    drive("R2 sub edge ok", rfmt(1,2,7,0,'h22), 32'hFFFFFFFF, 32'h7FFFFFFF, 1, 32'h80000000, 7, 1, 0, 0);
    // R3 unsigned wrap
    drive("R3 addu wrap", rfmt(1,2,9,0,'h21), 32'h7FFFFFFF, 32'd1, 1, 32'h80000000, 9, 1, 0, 0);
    drive("R3 subu wrap", rfmt(1,2,9,0,'h23), 32'h80000000, 32'd1, 1, 32'h7FFFFFFF, 9, 1, 0, 0);
    drive("R3 addiu wrap", ifmt('h09,1,10,16'hFFFF), 32'h80000000, 32'h0, 1, 32'h7FFFFFFF, 10, 1, 0, 0);
    // R4 logic
    drive("R4 and", rfmt(1,2,11,0,'h24), 32'hF0F0_1234, 32'h0FF0_FF00, 1, 32'h00F0_1200, 11, 1, 0, 0);
    drive("R4 or",  rfmt(1,2,11,0,'h25), 32'hF000_0001, 32'h0000_1000, 1, 32'hF000_1001, 11, 1, 0, 0);
    drive("R4 xor", rfmt(1,2,11,0,'h26), 32'hFFFF_0000, 32'hFF00_FF00, 1, 32'h00FF_FF00, 11, 1, 0, 0);
    drive("R4 nor", rfmt(1,2,11,0,'h27), 32'hF000_0000, 32'h0000_000F, 1, 32'h0FFF_FFF0, 11, 1, 0, 0);
    // R5 compares
    drive("R5 slt neg<pos",  rfmt(1,2,12,0,'h2A), 32'hFFFFFFFF, 32'd1, 1, 32'd1, 12, 1, 0, 0);
    drive("R5 sltu big>1",   rfmt(1,2,12,0,'h2B), 32'hFFFFFFFF, 32'd1, 1, 32'd0, 12, 1, 0, 0);
    drive("R5 slt equal",    rfmt(1,2,12,0,'h2A), 32'd7, 32'd7, 1, 32'd0, 12, 1, 0, 0);
    drive("R5 slti -2<-1",   ifmt('h0A,1,13,16'hFFFF), 32'hFFFFFFFE, 32'h0, 1, 32'd1, 13, 1, 0, 0);
    drive("R5 sltiu sext",   ifmt('h0B,1,13,16'hFFFF), 32'hFFFFFFFE, 32'h0, 1, 32'd1, 13, 1, 0, 0);
    drive("R5 sltiu 5<3",    ifmt('h0B,1,13,16'h0003), 32'd5, 32'h0, 1, 32'd0, 13, 1, 0, 0);
    // R6 constant shifts
    drive("R6 sll", rfmt(9,2,14,4,'h00), 32'hFFFFFFFF, 32'h8000_000F, 1, 32'h0000_00F0, 14, 1, 0, 0);
    drive("R6 srl", rfmt(9,2,14,31,'h02), 32'h0, 32'h8000_0000, 1, 32'h1, 14, 1, 0, 0);
    drive("R6 sra", rfmt(9,2,14,8,'h03), 32'h0, 32'h8000_1200, 1, 32'hFF80_0012, 14, 1, 0, 0);
    // R7 variable shifts, high rs bits ignored
    drive("R7 sllv", rfmt(1,2,15,0,'h04), 32'hFFFF_FFE3, 32'h0000_0001, 1, 32'h0000_0008, 15, 1, 0, 0);
    drive("R7 srlv", rfmt(1,2,15,0,'h06), 32'h0000_0124, 32'hF000_0000, 1, 32'h0F00_0000, 15, 1, 0, 0);
    drive("R7 srav", rfmt(1,2,15,0,'h07), 32'h8000_0020, 32'h8000_0000, 1, 32'h8000_0000, 15, 1, 0, 0);
    // R8 immediate extension
    drive("R8 addiu sext", ifmt('h09,1,16,16'h8000), 32'd0, 32'h0, 1, 32'hFFFF8000, 16, 1, 0, 0);
    drive("R8 andi zext",  ifmt('h0C,1,16,16'hFFFF), 32'hFFFF_FFFF, 32'h0, 1, 32'h0000_FFFF, 16, 1, 0, 0);
    drive("R8 ori zext",   ifmt('h0D,1,16,16'h8001), 32'h0000_0000, 32'h0, 1, 32'h0000_8001, 16, 1, 0, 0);
    drive("R8 xori zext",  ifmt('h0E,1,16,16'hFFFF), 32'hFFFF_0F0F, 32'h0, 1, 32'hFFFF_F0F0, 16, 1, 0, 0);
    // R9 upper immediate
    drive("R9 lui", ifmt('h0F,0,17,16'hBEEF), 32'h1234_5678, 32'h0, 1, 32'hBEEF_0000, 17, 1, 0, 0);
    // R10 destination selection and register zero
    drive("R10 rtype uses rd", {6'h00, 5'd1, 5'd2, 5'd30, 5'd0, 6'h21}, 32'd1, 32'd1, 1, 32'd2, 30, 1, 0, 0);
    drive("R10 itype uses rt", {6'h0D, 5'd1, 5'd21, 16'h0000}, 32'd3, 32'h0, 1, 32'd3, 21, 1, 0, 0);
    drive("R10 itype dst0", ifmt('h09,1,0,16'h0001), 32'd1, 32'h0, 1, 32'd2, 0, 0, 0, 0);
    // R11 reserved encodings
    drive("R11 rtype funct 0x08", rfmt(1,2,3,0,'h08), 32'h7FFFFFFF, 32'd1, 0, 32'h0, 3, 0, 0, 1);
    drive("R11 rtype funct 0x01", rfmt(1,2,3,0,'h01), 32'h0, 32'h0, 0, 32'h0, 3, 0, 0, 1);
    drive("R11 load opcode", ifmt('h23,1,4,16'h0004), 32'h0, 32'h0, 0, 32'h0, 4, 0, 0, 1);
    drive("R11 jump opcode", 32'h0800_0000 | 32'h0004_0000, 32'h0, 32'h0, 0, 32'h0, 4, 0, 0, 1);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule